// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a countdown watchdog reached through a small word-wide register interface. Software loads a reload value, then turns the timer on through the control register. From then on the count falls by one on each tick. Software must write a fixed 16-bit key to the restart register before the count runs out; a matching key reloads the count and restarts the countdown. If the count reaches zero, the block raises a one-cycle expiry pulse and halts. It stays halted until software restarts it with the key, or turns it off and on again.

The tick comes from one of two sources. It can be every cycle of the block clock. It can also be a 1 MHz time base, made by dividing the block clock by a parameter that gives the clock rate in MHz. Three control bits route the expiry pulse to separate outputs: a reset request, an interrupt and an external reset. A further control bit is passed out as a static choice between full-chip reset and SoC-only reset. A control write is accepted only if it flips the enable bit. This stops a stray write from reconfiguring a running timer.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, the count and reload registers read 0x03EF1480, the control register reads 0, the pulse-width register reads 0x000000FF, and every expiry output is low.
- R2: A read request returns its data on `rdata_o` in the cycle after the request. The byte offsets are 0x00 for the count, 0x04 for the reload value, 0x0C for the control register (bits [5:0], upper bits read 0) and 0x18 for the pulse-width register.
- R3: Writes to offset 0x00 do not change the count. Reads of the restart offset 0x08 return 0. Reads of any other offset, or of an address with bits [1:0] non-zero, return 0, and writes to them change nothing.
- R4: A write to offset 0x08 whose bits [15:0] equal 0x4755 copies the reload value into the count. The countdown then runs if the timer is enabled. A write with any other value in bits [15:0] leaves the count unchanged.
- R5: A control write is stored only if its bit 0 differs from the stored enable bit. Every other control write leaves the register unchanged.
- R6: A control write that sets bit 0 while disabled loads the count from the reload value and starts counting. A control write that clears bit 0 while enabled stops counting and freezes the count.
- R7: With control bit 4 clear, the count falls by one on every clock cycle. With bit 4 set, it falls once every CLK_MHZ cycles, counted from the cycle in which the count was loaded.
- R8: With a count of N (N of 0 is treated as 1), `expire_o` goes high for exactly one cycle. This happens N ticks after the load, in the cycle in which the count first reads 0. The counter then stays at 0 with no further pulses until it is restarted or re-enabled.
- R9: During the expiry pulse, `sys_rst_req_o`, `irq_o` and `ext_rst_o` are high exactly when control bits 1, 2 and 3, respectively, are set. `full_chip_o` continuously follows control bit 5.
- R10: A write to offset 0x18 stores data bits [PW_BITS-1:0]. The bits above them read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| expire_o | output | 1 | One-cycle expiry pulse |
| sys_rst_req_o | output | 1 | Expiry pulse gated by control bit 1 |
| irq_o | output | 1 | Expiry pulse gated by control bit 2 |
| ext_rst_o | output | 1 | Expiry pulse gated by control bit 3 |
| full_chip_o | output | 1 | Reset scope select (control bit 5) |

## Verification
The bench builds the block with CLK_MHZ set to 4 and PW_BITS set to 8. With a divide ratio of 4, the prescaled tick gives an exact expiry cycle of four times the reload value. This is checked against the every-cycle mode within a few dozen cycles, where the default of 24 would stretch every slow-tick test sixfold. Short reload values, including zero, bring expiry, the stop after expiry, and the keyed restart after expiry within a few cycles. A reload of 1000 lets a timer that has been stopped be read back at a known frozen count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DATA_W = 32;

  localparam logic [7:0] OFF_COUNT   = 8'h00;
  localparam logic [7:0] OFF_RELOAD  = 8'h04;
  localparam logic [7:0] OFF_RESTART = 8'h08;
  localparam logic [7:0] OFF_CTRL    = 8'h0C;
  localparam logic [7:0] OFF_PWIDTH  = 8'h18;

  localparam logic [15:0] RESTART_KEY = 16'h4755;

  localparam int unsigned CTRL_W     = 6;
  localparam int unsigned CB_EN      = 0;
  localparam int unsigned CB_SYSRST  = 1;
  localparam int unsigned CB_IRQ     = 2;
  localparam int unsigned CB_EXTRST  = 3;
  localparam int unsigned CB_SLOW    = 4;
  localparam int unsigned CB_FULL    = 5;
endpackage

// File: rtl/wdt_bus_regs.sv
module wdt_bus_regs
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned PW_BITS    = 8,
  parameter logic [31:0] RELOAD_RST = 32'h03EF1480,
  parameter logic [31:0] PW_RST     = 32'h000000FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              load_o,
  output logic              go_o,
  output logic              halt_o
);
  logic              aligned, wr, rd;
  logic              sel_cnt, sel_rld, sel_rst, sel_ctl, sel_pw;
  logic              key_hit, ctl_wr, en_on, en_off;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  reload_q;
  logic [PW_BITS-1:0] pw_q;
  logic [DATA_W-1:0] rdata_d, rdata_q;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr      = req_i & we_i & aligned;
  assign rd      = req_i & ~we_i & aligned;

  assign sel_cnt = (addr_i == ADDR_W'(OFF_COUNT));
  assign sel_rld = (addr_i == ADDR_W'(OFF_RELOAD));
  assign sel_rst = (addr_i == ADDR_W'(OFF_RESTART));
  assign sel_ctl = (addr_i == ADDR_W'(OFF_CTRL));
  assign sel_pw  = (addr_i == ADDR_W'(OFF_PWIDTH));

  assign key_hit = wr & sel_rst & (wdata_i[15:0] == RESTART_KEY);
  assign ctl_wr  = wr & sel_ctl;
  // only enable transitions are accepted
  assign en_on   = ctl_wr &  wdata_i[CB_EN] & ~ctrl_q[CB_EN];
  assign en_off  = ctl_wr & ~wdata_i[CB_EN] &  ctrl_q[CB_EN];

  assign load_o  = key_hit | en_on;
  assign go_o    = en_on | (key_hit & ctrl_q[CB_EN]);
  assign halt_o  = en_off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= CNT_W'(RELOAD_RST);
      pw_q     <= PW_BITS'(PW_RST);
    end else begin
      if (en_on || en_off) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (wr && sel_rld)   reload_q <= wdata_i[CNT_W-1:0];
      if (wr && sel_pw)    pw_q <= wdata_i[PW_BITS-1:0];
    end
  end

  always_comb begin
    rdata_d = '0;
    if (rd) begin
      unique case (1'b1)
        sel_cnt: rdata_d = DATA_W'(count_i);
        sel_rld: rdata_d = DATA_W'(reload_q);
        sel_ctl: rdata_d = DATA_W'(ctrl_q);
        sel_pw:  rdata_d = DATA_W'(pw_q);
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata_o  = rdata_q;
  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;

  // R5
  ctrl_toggle_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_q) |-> (ctrl_q[CB_EN] != $past(ctrl_q[CB_EN])));
endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int unsigned CLK_MHZ = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic slow_i,
  output logic tick_o
);
  generate
    if (CLK_MHZ <= 1) begin : g_nodiv
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned PRE_W = $clog2(CLK_MHZ);
      localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CLK_MHZ - 1);
      logic [PRE_W-1:0] pre_q;
      logic             wrap;

      assign wrap   = (pre_q == PRE_MAX);
      assign tick_o = slow_i ? wrap : 1'b1;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pre_q <= '0;
        else if (clr_i)  pre_q <= '0;
        else if (wrap)   pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
      end

      // R7
      prescale_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && slow_i && !clr_i) |=> (!tick_o || !slow_i));
    end
  endgenerate
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned CNT_W    = 32,
  parameter logic [31:0] CNT_RST  = 32'h03EF1480
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             go_i,
  input  logic             halt_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             fire_o
);
  logic [CNT_W-1:0] count_q;
  logic             running_q, fire_q, last;

  assign last = (count_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= CNT_W'(CNT_RST);
      running_q <= 1'b0;
      fire_q    <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (halt_i) begin
        running_q <= 1'b0;
      end else if (load_i) begin
        count_q   <= load_val_i;
        running_q <= go_i;
      end else if (running_q && tick_i) begin
        if (last) begin
          count_q   <= '0;
          running_q <= 1'b0;
          fire_q    <= 1'b1;
        end else begin
          count_q <= count_q - 1'b1;
        end
      end
    end
  end

  assign count_o = count_q;
  assign fire_o  = fire_q;

  // R8
  fire_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |=> !fire_q);
  // R6
  frozen_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_q && !load_i) |=> $stable(count_q));
  // R7
  no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (count_q <= $past(count_q)));
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned CLK_MHZ    = 24,
  parameter int unsigned PW_BITS    = 8,
  parameter logic [31:0] RELOAD_RST = 32'h03EF1480
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              expire_o,
  output logic              sys_rst_req_o,
  output logic              irq_o,
  output logic              ext_rst_o,
  output logic              full_chip_o
);
  logic [CTRL_W-1:0] ctrl;
  logic [CNT_W-1:0]  reload, count;
  logic              load, go, halt, tick, fire;

  wdt_bus_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PW_BITS(PW_BITS),
    .RELOAD_RST(RELOAD_RST), .PW_RST(32'h000000FF)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .count_i(count),
    .rdata_o(rdata_o), .ctrl_o(ctrl), .reload_o(reload),
    .load_o(load), .go_o(go), .halt_o(halt)
  );

  wdt_tick_gen #(.CLK_MHZ(CLK_MHZ)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(load),
    .slow_i(ctrl[CB_SLOW]), .tick_o(tick)
  );

  wdt_countdown #(.CNT_W(CNT_W), .CNT_RST(RELOAD_RST)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .go_i(go),
    .halt_i(halt), .load_val_i(reload), .tick_i(tick),
    .count_o(count), .fire_o(fire)
  );

  assign expire_o      = fire;
  assign sys_rst_req_o = fire & ctrl[CB_SYSRST];
  assign irq_o         = fire & ctrl[CB_IRQ];
  assign ext_rst_o     = fire & ctrl[CB_EXTRST];
  assign full_chip_o   = ctrl[CB_FULL];

  // R9
  gated_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_req_o || irq_o || ext_rst_o) |-> expire_o);
endmodule

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_tb_top;
  localparam int unsigned DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        expire, sys_rst, irq, ext_rst, full_chip;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  wdt_keyed #(.ADDR_W(8), .CNT_W(32), .CLK_MHZ(DIV), .PW_BITS(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .expire_o(expire),
    .sys_rst_req_o(sys_rst), .irq_o(irq), .ext_rst_o(ext_rst),
    .full_chip_o(full_chip)
  );

  task automatic chk(input string req_s, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req_s, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // call right after the write that loads the count
  task automatic wait_expiry(input string req_s, input int exp_n);
    int n;
    n = 0;
    while (!expire && n < exp_n + 50) begin
      @(negedge clk);
      n++;
    end
    chk(req_s, n, exp_n);
    @(negedge clk);
    chk({req_s, " pulse one cycle"}, {31'b0, expire}, 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 expire low", {27'b0, expire, sys_rst, irq, ext_rst, full_chip}, 32'd0);
    bus_rd(8'h00, d); chk("R1 count", d, 32'h03EF1480);
    bus_rd(8'h04, d); chk("R1 reload", d, 32'h03EF1480);
    bus_rd(8'h0C, d); chk("R1 ctrl", d, 32'h0);
    bus_rd(8'h18, d); chk("R1 pwidth", d, 32'h000000FF);
  endtask

  task automatic t_map;
    logic [31:0] d;
    bus_wr(8'h04, 32'h0000_1234);
    bus_rd(8'h04, d); chk("R2 reload readback", d, 32'h0000_1234);
    bus_wr(8'h00, 32'h0000_0055);
    bus_rd(8'h00, d); chk("R3 count write ignored", d, 32'h03EF1480);
    bus_rd(8'h08, d); chk("R3 restart reads 0", d, 32'h0);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_rd(8'h10, d); chk("R3 unmapped reads 0", d, 32'h0);
    bus_wr(8'h05, 32'h0000_0077);
    bus_rd(8'h04, d); chk("R3 misaligned write ignored", d, 32'h0000_1234);
    bus_rd(8'h06, d); chk("R3 misaligned read 0", d, 32'h0);
    bus_wr(8'h18, 32'hFFFF_FF3C);
    bus_rd(8'h18, d); chk("R10 pwidth low bits", d, 32'h0000_003C);
  endtask

  task automatic t_key_idle;
    logic [31:0] d;
    bus_wr(8'h04, 32'h0000_0321);
    bus_wr(8'h08, 32'h0000_4756);
    bus_rd(8'h00, d); chk("R4 wrong key ignored", d, 32'h03EF1480);
    bus_wr(8'h08, 32'hABCD_4755);
    bus_rd(8'h00, d); chk("R4 key loads count", d, 32'h0000_0321);
    idle(10);
    bus_rd(8'h00, d); chk("R4 disabled stays loaded", d, 32'h0000_0321);
  endtask

  task automatic t_ctrl_toggle;
    logic [31:0] d;
    bus_wr(8'h0C, 32'h0000_001E);
    bus_rd(8'h0C, d); chk("R5 write without enable dropped", d, 32'h0);
    bus_wr(8'h04, 32'd1000);
    bus_wr(8'h0C, 32'h0000_0001);
    bus_wr(8'h0C, 32'h0000_000F);
    bus_rd(8'h0C, d); chk("R5 rewrite while enabled dropped", d, 32'h1);
    bus_wr(8'h0C, 32'h0000_0000);
    bus_rd(8'h0C, d); chk("R5 disable accepted", d, 32'h0);
  endtask

  task automatic t_stop;
    logic [31:0] d;
    bus_wr(8'h04, 32'd1000);
    bus_wr(8'h0C, 32'h0000_0001);
    idle(10);
    bus_wr(8'h0C, 32'h0000_0000);
    bus_rd(8'h00, d); chk("R6 frozen count", d, 32'd989);
    idle(15);
    bus_rd(8'h00, d); chk("R6 stays frozen", d, 32'd989);
  endtask

  task automatic t_fast_expiry;
    logic [31:0] d;
    int seen;
    bus_wr(8'h04, 32'd6);
    bus_wr(8'h0C, 32'h0000_0001);
    wait_expiry("R8 fast expiry at 6", 6);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (expire) seen++;
    end
    chk("R8 no pulse after stop", seen, 0);
    bus_rd(8'h00, d); chk("R8 count held at 0", d, 32'h0);
    bus_wr(8'h08, 32'h0000_4755);
    wait_expiry("R4 keyed restart after expiry", 6);
    bus_wr(8'h0C, 32'h0000_0000);
  endtask

  task automatic t_zero_reload;
    bus_wr(8'h04, 32'd0);
    bus_wr(8'h0C, 32'h0000_0001);
    wait_expiry("R8 zero reload expires on first tick", 1);
    bus_wr(8'h0C, 32'h0000_0000);
  endtask

  task automatic t_slow_tick;
    bus_wr(8'h04, 32'd5);
    bus_wr(8'h0C, 32'h0000_0011);
    wait_expiry("R7 slow tick expiry", 5 * DIV);
    bus_wr(8'h0C, 32'h0000_0000);
    bus_wr(8'h0C, 32'h0000_0001);
    wait_expiry("R7 fast tick expiry", 5);
    bus_wr(8'h0C, 32'h0000_0000);
  endtask

  task automatic t_gating;
    bus_wr(8'h04, 32'd3);
    bus_wr(8'h0C, 32'h0000_002F);
    chk("R9 full chip select", {31'b0, full_chip}, 32'd1);
    while (!expire) @(negedge clk);
    chk("R9 all gated outputs", {29'b0, sys_rst, irq, ext_rst}, 32'h7);
    bus_wr(8'h0C, 32'h0000_0000);
    chk("R9 full chip cleared", {31'b0, full_chip}, 32'd0);
    bus_wr(8'h0C, 32'h0000_0005);
    while (!expire) @(negedge clk);
    chk("R9 interrupt only", {29'b0, sys_rst, irq, ext_rst}, 32'h2);
    @(negedge clk);
    chk("R9 gated outputs drop", {29'b0, sys_rst, irq, ext_rst}, 32'h0);
    bus_wr(8'h0C, 32'h0000_0000);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_map();
    t_key_idle();
    t_ctrl_toggle();
    t_stop();
    t_fast_expiry();
    t_zero_reload();
    t_slow_tick();
    t_gating();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog timeout, bench hung");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule